// File: doc/BRIEF.md
# Gray-Coded Photon Position Decoder

This block turns one detected photon event per clock into a position on a 2048 by 2048 grid. A photon-counting camera places a stack of Gray-coded masks over each axis. Each mask drives a thresholded one-bit channel, so the coarse bits of each coordinate arrive as a Gray code. Two amplitude channels add one finer bit per axis. A third amplitude channel carries the total energy of the event.

The decoder rebuilds the 11-bit Gray word for each axis and converts it to binary. It also tests the total energy against a programmable window. If the energy is too high, two photons probably arrived together and the position cannot be trusted. If it is too low, the signal is too weak. Either way the event is flagged as rejected instead of accepted. The pipeline has a fixed latency of three cycles and takes a new event every cycle. The two window limits are set through a small write port.

Top module: `photon_pos_decoder`

## Requirements
- R1: The X coordinate `out_x` is the binary value of the 11-bit Gray word {`ev_mask[9:0]`, fine X bit}, where `ev_mask[9]` is the most significant Gray bit.
- R2: The Y coordinate `out_y` is the binary value of the 11-bit Gray word {`ev_mask[19:10]`, fine Y bit}, where `ev_mask[19]` is the most significant Gray bit.
- R3: The fine X Gray bit is 1 exactly when 2*`ev_amp_x` > `ev_energy`, and the fine Y Gray bit is 1 exactly when 2*`ev_amp_y` > `ev_energy`. Equality gives 0.
- R4: An event is accepted (`out_valid`=1, `out_reject`=0) when low limit <= `ev_energy` <= high limit. Both ends are inclusive.
- R5: An event whose energy is above the high limit is taken as a coincident pair and is flagged with `out_reject`=1 and `out_valid`=0.
- R6: An event whose energy is below the low limit is flagged with `out_reject`=1 and `out_valid`=0.
- R7: An event presented with `ev_valid`=1 before clock edge t shows its result after edge t+2, three edges in all. Events on consecutive cycles come out on consecutive cycles in order.
- R8: `out_valid` and `out_reject` are never 1 together. Both are 0 in any cycle that carries no event.
- R9: Limits are written with `cfg_we`=1, where `cfg_sel`=0 writes the low limit and `cfg_sel`=1 writes the high limit. A written limit applies to events presented after the write edge. Reset values are low=0 and high=1023.
- R10: Synchronous reset `rst` clears `out_valid` and `out_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the energy limits |
| cfg_sel | input | 1 | Limit select: 0 low, 1 high |
| cfg_data | input | 10 | Limit value |
| ev_valid | input | 1 | An event is present this cycle |
| ev_mask | input | 20 | Mask channel bits: [9:0] X, [19:10] Y |
| ev_amp_x | input | 10 | Amplitude used for the fine X bit |
| ev_amp_y | input | 10 | Amplitude used for the fine Y bit |
| ev_energy | input | 10 | Total event energy |
| out_valid | output | 1 | Accepted event |
| out_reject | output | 1 | Event rejected by the energy window |
| out_x | output | 11 | Binary X coordinate |
| out_y | output | 11 | Binary Y coordinate |

## Verification
The bench drives energies exactly at each limit and one step outside it. A design that compares with the wrong strictness shows up here, because it either rejects a boundary photon or lets a coincident pair through. Fine-bit cases put twice the amplitude exactly at the energy and one above it, so an off-by-one or swapped comparison flips the coordinate's least significant bit. Mask patterns with all ones and alternating bits catch a conversion that ignores the carry chain or swaps the axes. Back-to-back events and a check that the flag stays low one cycle early expose a wrong pipeline depth, or a flag that has drifted out of step with its data.

// File: rtl/phot_pkg.sv
package phot_pkg;

    localparam int MASK_BITS = 10;
    localparam int COORD_W   = MASK_BITS + 1;
    localparam int AMP_W     = 10;
    localparam int CH_BITS   = 2 * MASK_BITS;
    localparam logic [AMP_W-1:0] THR_LO_RST = '0;
    localparam logic [AMP_W-1:0] THR_HI_RST = '1;

    typedef enum logic {
        THR_LOW  = 1'b0,
        THR_HIGH = 1'b1
    } thr_sel_e;

    // Registered raw event (stage 1)
    typedef struct packed {
        logic                 valid;
        logic [MASK_BITS-1:0] gx;
        logic [MASK_BITS-1:0] gy;
        logic [AMP_W-1:0]     ax;
        logic [AMP_W-1:0]     ay;
        logic [AMP_W-1:0]     ae;
    } raw_ev_t;

    // Full Gray words with the window verdict (stage 2)
    typedef struct packed {
        logic               valid;
        logic               legit;
        logic [COORD_W-1:0] gx;
        logic [COORD_W-1:0] gy;
    } gray_ev_t;

    // Fine bit: set when the axis amplitude is above half the energy
    function automatic logic fine_bit(input logic [AMP_W-1:0] amp,
                                      input logic [AMP_W-1:0] energy);
        logic [AMP_W:0] dbl;
        logic [AMP_W:0] en;
        dbl = {amp, 1'b0};
        en  = {1'b0, energy};
        return dbl > en;
    endfunction

    function automatic logic in_window(input logic [AMP_W-1:0] energy,
                                       input logic [AMP_W-1:0] lo,
                                       input logic [AMP_W-1:0] hi);
        return (energy >= lo) && (energy <= hi);
    endfunction

endpackage

// File: rtl/phot_thr_regs.sv
module phot_thr_regs
    import phot_pkg::*;
#(
    parameter int W = AMP_W,
    parameter logic [W-1:0] LO_INIT = THR_LO_RST,
    parameter logic [W-1:0] HI_INIT = THR_HI_RST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  thr_sel_e     sel,
    input  logic [W-1:0] data,
    output logic [W-1:0] thr_lo,
    output logic [W-1:0] thr_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_lo <= LO_INIT;
            thr_hi <= HI_INIT;
        end else if (we) begin
            if (sel == THR_LOW) thr_lo <= data;
            else                thr_hi <= data;
        end
    end

endmodule

// File: rtl/phot_front.sv
module phot_front
    import phot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  raw_ev_t          s1,
    input  logic [AMP_W-1:0] thr_lo,
    input  logic [AMP_W-1:0] thr_hi,
    output gray_ev_t         s2
);

    gray_ev_t nxt;

    always_comb begin
        nxt.valid = s1.valid;
        nxt.legit = in_window(s1.ae, thr_lo, thr_hi);
        nxt.gx    = {s1.gx, fine_bit(s1.ax, s1.ae)};
        nxt.gy    = {s1.gy, fine_bit(s1.ay, s1.ae)};
    end

    always_ff @(posedge clk) begin
        if (rst) s2 <= '0;
        else     s2 <= nxt;
    end

endmodule

// File: rtl/phot_gray2bin.sv
module phot_gray2bin #(
    parameter int W = 11
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);

    assign bin[W-1] = gray[W-1];

    generate
        for (genvar i = W - 2; i >= 0; i--) begin : g_chain
            assign bin[i] = bin[i+1] ^ gray[i];
        end
    endgenerate

endmodule

// File: rtl/photon_pos_decoder.sv
module photon_pos_decoder
    import phot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [AMP_W-1:0]   cfg_data,
    input  logic               ev_valid,
    input  logic [CH_BITS-1:0] ev_mask,
    input  logic [AMP_W-1:0]   ev_amp_x,
    input  logic [AMP_W-1:0]   ev_amp_y,
    input  logic [AMP_W-1:0]   ev_energy,
    output logic               out_valid,
    output logic               out_reject,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y
);

    raw_ev_t            s1_q;
    gray_ev_t           s2_q;
    logic [AMP_W-1:0]   thr_lo;
    logic [AMP_W-1:0]   thr_hi;
    logic [COORD_W-1:0] bin_x;
    logic [COORD_W-1:0] bin_y;
    thr_sel_e           sel_e;

    assign sel_e = thr_sel_e'(cfg_sel);

    phot_thr_regs #(.W(AMP_W)) u_thr (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (sel_e),
        .data   (cfg_data),
        .thr_lo (thr_lo),
        .thr_hi (thr_hi)
    );

    // Stage 1: capture the event
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= ev_valid;
            s1_q.gx    <= ev_mask[MASK_BITS-1:0];
            s1_q.gy    <= ev_mask[CH_BITS-1:MASK_BITS];
            s1_q.ax    <= ev_amp_x;
            s1_q.ay    <= ev_amp_y;
            s1_q.ae    <= ev_energy;
        end
    end

    // Stage 2: fine bits and energy window
    phot_front u_front (
        .clk    (clk),
        .rst    (rst),
        .s1     (s1_q),
        .thr_lo (thr_lo),
        .thr_hi (thr_hi),
        .s2     (s2_q)
    );

    // Stage 3: Gray to binary per axis
    phot_gray2bin #(.W(COORD_W)) u_g2b_x (.gray(s2_q.gx), .bin(bin_x));
    phot_gray2bin #(.W(COORD_W)) u_g2b_y (.gray(s2_q.gy), .bin(bin_y));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_reject <= 1'b0;
            out_x      <= '0;
            out_y      <= '0;
        end else begin
            out_valid  <= s2_q.valid & s2_q.legit;
            out_reject <= s2_q.valid & ~s2_q.legit;
            out_x      <= bin_x;
            out_y      <= bin_y;
        end
    end

endmodule

// File: rtl/phot_decoder_chk.sv
module phot_decoder_chk
    import phot_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ev_valid,
    input logic [CH_BITS-1:0] ev_mask,
    input logic [AMP_W-1:0]   s1_energy,
    input logic [AMP_W-1:0]   thr_lo,
    input logic [AMP_W-1:0]   thr_hi,
    input logic               out_valid,
    input logic               out_reject,
    input logic [COORD_W-1:0] out_x,
    input logic [COORD_W-1:0] out_y
);

    logic [1:0]         since_rst;
    logic [COORD_W-1:0] gx_back;
    logic [COORD_W-1:0] gy_back;
    logic               win_ok;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    assign gx_back = out_x ^ (out_x >> 1);
    assign gy_back = out_y ^ (out_y >> 1);
    assign win_ok  = (s1_energy >= thr_lo) && (s1_energy <= thr_hi);

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_reject));

    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3) |-> ((out_valid || out_reject) == $past(ev_valid, 3)));

    a_r4_accept_in_window: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2 && out_valid) |-> $past(win_ok, 2));

    a_r5_reject_outside: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2 && out_reject) |-> !$past(win_ok, 2));

    a_r1_x_roundtrip: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && (out_valid || out_reject)) |->
            (gx_back[COORD_W-1:1] == $past(ev_mask[MASK_BITS-1:0], 3)));

    a_r2_y_roundtrip: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && (out_valid || out_reject)) |->
            (gy_back[COORD_W-1:1] == $past(ev_mask[CH_BITS-1:MASK_BITS], 3)));

    a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 0) |-> (!out_valid && !out_reject));

endmodule

bind photon_pos_decoder phot_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_mask    (ev_mask),
    .s1_energy  (s1_q.ae),
    .thr_lo     (thr_lo),
    .thr_hi     (thr_hi),
    .out_valid  (out_valid),
    .out_reject (out_reject),
    .out_x      (out_x),
    .out_y      (out_y)
);

// File: tb/tb_photon_pos_decoder.sv
module tb_photon_pos_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [9:0]  cfg_data = '0;
    logic        ev_valid = 1'b0;
    logic [19:0] ev_mask = '0;
    logic [9:0]  ev_amp_x = '0;
    logic [9:0]  ev_amp_y = '0;
    logic [9:0]  ev_energy = '0;
    logic        out_valid;
    logic        out_reject;
    logic [10:0] out_x;
    logic [10:0] out_y;

    int checks = 0;
    int errors = 0;
    logic [9:0] cur_lo = 10'd0;
    logic [9:0] cur_hi = 10'd1023;

    always #5 clk = ~clk;

    photon_pos_decoder dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .ev_valid(ev_valid), .ev_mask(ev_mask), .ev_amp_x(ev_amp_x), .ev_amp_y(ev_amp_y),
        .ev_energy(ev_energy), .out_valid(out_valid), .out_reject(out_reject),
        .out_x(out_x), .out_y(out_y)
    );

    function automatic logic [10:0] g2b(input logic [10:0] g);
        logic [10:0] b;
        b[10] = g[10];
        for (int i = 9; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [10:0] exp_coord(input logic [9:0] m, input logic [9:0] a,
                                              input logic [9:0] e);
        logic fine;
        fine = (2 * int'(a)) > int'(e);
        return g2b({m, fine});
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_thr(input logic sel, input logic [9:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) cur_hi = val; else cur_lo = val;
    endtask

    // One event, checked three edges later; also checks the flag is low one cycle early
    task automatic one_event(input string req, input logic [19:0] m, input logic [9:0] ax,
                             input logic [9:0] ay, input logic [9:0] e);
        logic ok;
        ok = (e >= cur_lo) && (e <= cur_hi);
        @(negedge clk);
        ev_valid = 1'b1; ev_mask = m; ev_amp_x = ax; ev_amp_y = ay; ev_energy = e;
        @(negedge clk);
        ev_valid = 1'b0;
        @(negedge clk);
        check("R7", "early flags", {30'd0, out_valid, out_reject}, 32'd0);
        @(negedge clk);
        check(req, "out_valid", {31'd0, out_valid}, {31'd0, ok});
        check(req, "out_reject", {31'd0, out_reject}, {31'd0, !ok});
        check(req, "out_x", {21'd0, out_x}, {21'd0, exp_coord(m[9:0], ax, e)});
        check(req, "out_y", {21'd0, out_y}, {21'd0, exp_coord(m[19:10], ay, e)});
        @(negedge clk);
        check("R8", "idle flags", {30'd0, out_valid, out_reject}, 32'd0);
    endtask

    task automatic t_reset;
        check("R10", "reset flags", {30'd0, out_valid, out_reject}, 32'd0);
        check("R10", "reset coords", {10'd0, out_x, out_y}, 32'd0);
    endtask

    task automatic t_gray_patterns;
        one_event("R1", 20'h003FF, 10'd100, 10'd10, 10'd150);
        one_event("R2", 20'hFFC00, 10'd10, 10'd100, 10'd150);
        one_event("R1", 20'h556AA, 10'd0, 10'd0, 10'd0);
        one_event("R2", 20'hAA955, 10'd500, 10'd500, 10'd900);
    endtask

    task automatic t_fine_bit;
        one_event("R3", 20'h12345, 10'd200, 10'd201, 10'd400);
        one_event("R3", 20'h00000, 10'd201, 10'd200, 10'd401);
    endtask

    task automatic t_defaults;
        one_event("R9", 20'h0F0F0, 10'd0, 10'd0, 10'd0);
        one_event("R9", 20'h0F0F0, 10'd600, 10'd600, 10'd1023);
    endtask

    task automatic t_window;
        write_thr(1'b0, 10'd100);
        write_thr(1'b1, 10'd700);
        one_event("R4", 20'h2468A, 10'd60, 10'd40, 10'd100);
        one_event("R4", 20'h2468A, 10'd400, 10'd300, 10'd700);
        one_event("R5", 20'h13579, 10'd400, 10'd300, 10'd701);
        one_event("R6", 20'h13579, 10'd60, 10'd40, 10'd99);
    endtask

    task automatic t_back_to_back;
        logic [19:0] m [4];
        logic [9:0]  e [4];
        m[0] = 20'h00001; e[0] = 10'd150;
        m[1] = 20'h80200; e[1] = 10'd800;
        m[2] = 20'h3C3C3; e[2] = 10'd50;
        m[3] = 20'hFFFFF; e[3] = 10'd400;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                logic ok;
                ok = (e[i-3] >= cur_lo) && (e[i-3] <= cur_hi);
                check("R7", "b2b valid", {31'd0, out_valid}, {31'd0, ok});
                check("R7", "b2b reject", {31'd0, out_reject}, {31'd0, !ok});
                check("R7", "b2b x", {21'd0, out_x},
                      {21'd0, exp_coord(m[i-3][9:0], 10'd90, e[i-3])});
            end
            if (i < 4) begin
                ev_valid = 1'b1; ev_mask = m[i]; ev_amp_x = 10'd90;
                ev_amp_y = 10'd90; ev_energy = e[i];
            end else begin
                ev_valid = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_gray_patterns();
        t_fine_bit();
        t_window();
        t_back_to_back();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cur_lo = 10'd0; cur_hi = 10'd1023;
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule